// File: doc/BRIEF.md
# Snoop Inquire Cycle Responder

This block answers inquiries that another bus master makes against the cache of its host. When the external address strobe is seen active, the block registers the snoop address and the invalidate request. In the next clock it presents the line address on a lookup port. The cache tag logic answers that port in the same clock, reporting whether the line is valid in the instruction cache or the data cache, and whether the data copy is modified.

Two clocks after the strobe, the block drives the active-low hit and hit-to-modified outputs. On a hit it issues a one-clock tag-state update command whose target state is shared or invalid, chosen by the captured invalidate request. On a modified hit it also issues a one-clock writeback request. Hit-to-modified is then held until the writeback-done input is seen, which holds other masters off the line. A strobe that arrives while a modified line is in flight or awaiting writeback is refused, and an error pulse reports the refusal.

Top module: `snoop_responder`

## Requirements
- R1: When a strobe is accepted at clock edge T and its line is valid in either cache, `hit_n` is low after edge T+2.
- R2: When an accepted strobe finds the line valid in neither cache, `hit_n` is high after edge T+2.
- R3: `hit_n` changes only at the result point of an accepted inquiry and holds its value in between.
- R4: `hitm_n` goes low at the same point as `hit_n` only when the line is valid and modified in the data cache (`lk_dvalid` and `lk_dmod` both 1).
- R5: Once low, `hitm_n` stays low until `wb_done` is sampled high, and goes high after that edge.
- R6: On a hit, `upd_vld` pulses for one clock at the result point with `upd_line` equal to the captured line address and `upd_state` 0 (shared) if the captured invalidate was 0, or 1 (invalid) if it was 1.
- R7: On a miss, no update command is issued.
- R8: The line address (`snp_addr` bits above the line offset) and `snp_inval` are taken only in the strobe clock; later changes on them have no effect.
- R9: On a modified hit, `wb_req` pulses for one clock at the result point with `wb_line` equal to the captured line address.
- R10: A strobe sampled while a modified hit is between lookup and the release of `hitm_n` (including the clock in which `wb_done` is sampled) is refused: `snp_err` pulses one clock later and no output is changed by it.
- R11: After reset, `hit_n` and `hitm_n` are high, and `upd_vld`, `wb_req` and `snp_err` are low.
- R12: Strobes in consecutive clocks are each answered in order, one result per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_strobe_n | input | 1 | External address strobe, active low |
| snp_inval | input | 1 | Invalidate request, sampled with the strobe |
| snp_addr | input | ADDR_W | Snoop address |
| lk_line | output | ADDR_W-OFS_W | Line address presented to the tag lookup |
| lk_ivalid | input | 1 | Line valid in instruction cache |
| lk_dvalid | input | 1 | Line valid in data cache |
| lk_dmod | input | 1 | Data cache copy is modified |
| hit_n | output | 1 | Inquiry hit, active low |
| hitm_n | output | 1 | Hit to modified line, active low |
| upd_vld | output | 1 | Tag-state update command strobe |
| upd_line | output | ADDR_W-OFS_W | Line targeted by the update |
| upd_state | output | 1 | Final state: 0 shared, 1 invalid |
| wb_req | output | 1 | Writeback request pulse |
| wb_line | output | ADDR_W-OFS_W | Line to write back |
| wb_done | input | 1 | Writeback completed |
| snp_err | output | 1 | Refused strobe pulse |

## Verification
The bench builds the block with a 12-bit address and a 4-bit line offset. This gives 256 line addresses, so its behavioural tag table covers the whole line space, and address changes inside the offset bits are shown to have no effect. The short addresses also make random inquiries collide often with the few valid and modified lines. Refusals therefore occur in every timing position: during lookup, in the result stage, while `hitm_n` is held, and in the very clock in which `wb_done` arrives.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic {
    ST_SHARED  = 1'b0,
    ST_INVALID = 1'b1
  } line_state_e;

  typedef struct packed {
    logic hit;
    logic mod;
  } snoop_class_t;

  // Outcome of a lookup: hit in either cache, modified only in data cache.
  function automatic snoop_class_t classify(input logic iv, input logic dv, input logic dm);
    snoop_class_t r;
    r.hit = iv | dv;
    r.mod = dv & dm;
    return r;
  endfunction

  // Final line state chosen by the invalidate request.
  function automatic line_state_e end_state(input logic inval);
    return inval ? ST_INVALID : ST_SHARED;
  endfunction

endpackage

// File: rtl/snoop_capture.sv
module snoop_capture #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5,
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              inval,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              s1_vld,
  output logic [LINE_W-1:0] s1_line,
  output logic              s1_inval,
  output logic              rej
);

  logic take;
  assign take = !strobe_n && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_line  <= '0;
      s1_inval <= 1'b0;
      rej      <= 1'b0;
    end else begin
      s1_vld <= take;
      rej    <= !strobe_n && busy;
      if (take) begin
        s1_line  <= addr[ADDR_W-1:OFS_W];
        s1_inval <= inval;
      end
    end
  end

endmodule

// File: rtl/snoop_eval.sv
module snoop_eval
  import snoop_pkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_vld,
  input  logic [LINE_W-1:0] s1_line,
  input  logic              s1_inval,
  input  logic              lk_ivalid,
  input  logic              lk_dvalid,
  input  logic              lk_dmod,
  output logic [LINE_W-1:0] lk_line,
  output logic              mod_now,
  output logic              s2_vld,
  output logic [LINE_W-1:0] s2_line,
  output logic              s2_inval,
  output snoop_class_t      s2_cls
);

  snoop_class_t cls_now;

  assign lk_line = s1_line;
  assign cls_now = classify(lk_ivalid, lk_dvalid, lk_dmod);
  assign mod_now = s1_vld && cls_now.mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld   <= 1'b0;
      s2_line  <= '0;
      s2_inval <= 1'b0;
      s2_cls   <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_line  <= s1_line;
        s2_inval <= s1_inval;
        s2_cls   <= cls_now;
      end
    end
  end

endmodule

// File: rtl/snoop_drive.sv
module snoop_drive
  import snoop_pkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s2_vld,
  input  logic [LINE_W-1:0] s2_line,
  input  logic              s2_inval,
  input  snoop_class_t      s2_cls,
  input  logic              wb_done,
  output logic              hit_n,
  output logic              hitm_n,
  output logic              upd_vld,
  output logic [LINE_W-1:0] upd_line,
  output line_state_e       upd_state,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line,
  output logic              pend
);

  logic release_now;
  assign pend        = !hitm_n;
  assign release_now = pend && wb_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_n     <= 1'b1;
      hitm_n    <= 1'b1;
      upd_vld   <= 1'b0;
      upd_line  <= '0;
      upd_state <= ST_SHARED;
      wb_req    <= 1'b0;
      wb_line   <= '0;
    end else begin
      upd_vld <= 1'b0;
      wb_req  <= 1'b0;
      if (release_now) hitm_n <= 1'b1;
      if (s2_vld) begin
        hit_n <= !s2_cls.hit;
        if (s2_cls.hit) begin
          upd_vld   <= 1'b1;
          upd_line  <= s2_line;
          upd_state <= end_state(s2_inval);
        end
        if (s2_cls.mod) begin
          hitm_n  <= 1'b0;
          wb_req  <= 1'b1;
          wb_line <= s2_line;
        end
      end
    end
  end

  assert_hitm_implies_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |-> !hit_n);

  assert_hit_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hit_n) |-> $past(s2_vld));

  assert_no_update_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |-> !hit_n);

  assert_wbreq_with_hitm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !hitm_n);

  assert_hitm_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hitm_n) |-> $past(wb_done));

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5,
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_strobe_n,
  input  logic              snp_inval,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [LINE_W-1:0] lk_line,
  input  logic              lk_ivalid,
  input  logic              lk_dvalid,
  input  logic              lk_dmod,
  output logic              hit_n,
  output logic              hitm_n,
  output logic              upd_vld,
  output logic [LINE_W-1:0] upd_line,
  output logic              upd_state,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line,
  input  logic              wb_done,
  output logic              snp_err
);

  logic              s1_vld, s1_inval, mod_now, s2_vld, s2_inval, pend, busy;
  logic [LINE_W-1:0] s1_line, s2_line;
  snoop_class_t      s2_cls;
  line_state_e       upd_st;

  // Any modified hit between lookup and hitm release blocks new inquiries.
  assign busy      = mod_now || (s2_vld && s2_cls.mod) || pend;
  assign upd_state = upd_st;

  snoop_capture #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .strobe_n(snp_strobe_n), .inval(snp_inval),
    .addr(snp_addr), .busy(busy), .s1_vld(s1_vld), .s1_line(s1_line),
    .s1_inval(s1_inval), .rej(snp_err)
  );

  snoop_eval #(.LINE_W(LINE_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .s1_vld(s1_vld), .s1_line(s1_line),
    .s1_inval(s1_inval), .lk_ivalid(lk_ivalid), .lk_dvalid(lk_dvalid),
    .lk_dmod(lk_dmod), .lk_line(lk_line), .mod_now(mod_now),
    .s2_vld(s2_vld), .s2_line(s2_line), .s2_inval(s2_inval), .s2_cls(s2_cls)
  );

  snoop_drive #(.LINE_W(LINE_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .s2_vld(s2_vld), .s2_line(s2_line),
    .s2_inval(s2_inval), .s2_cls(s2_cls), .wb_done(wb_done),
    .hit_n(hit_n), .hitm_n(hitm_n), .upd_vld(upd_vld), .upd_line(upd_line),
    .upd_state(upd_st), .wb_req(wb_req), .wb_line(wb_line), .pend(pend)
  );

  assert_no_inquiry_while_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |-> !s2_vld);

  assert_err_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_err |-> !s1_vld);

endmodule

// File: tb/snoop_responder_tb.sv
module snoop_responder_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int OFS_W  = 4;
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int NLINES = 1 << LINE_W;

  logic clk = 0, rst_n = 0;
  logic snp_strobe_n = 1, snp_inval = 0, wb_done = 0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [LINE_W-1:0] lk_line, upd_line, wb_line;
  logic lk_ivalid, lk_dvalid, lk_dmod;
  logic hit_n, hitm_n, upd_vld, upd_state, wb_req, snp_err;

  logic t_iv [NLINES];
  logic t_dv [NLINES];
  logic t_dm [NLINES];

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  assign lk_ivalid = t_iv[lk_line];
  assign lk_dvalid = t_dv[lk_line];
  assign lk_dmod   = t_dm[lk_line];

  snoop_responder #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .snp_strobe_n(snp_strobe_n), .snp_inval(snp_inval),
    .snp_addr(snp_addr), .lk_line(lk_line), .lk_ivalid(lk_ivalid),
    .lk_dvalid(lk_dvalid), .lk_dmod(lk_dmod), .hit_n(hit_n), .hitm_n(hitm_n),
    .upd_vld(upd_vld), .upd_line(upd_line), .upd_state(upd_state),
    .wb_req(wb_req), .wb_line(wb_line), .wb_done(wb_done), .snp_err(snp_err)
  );

  // Behavioural reference: list of accepted inquiries with their due cycle.
  int q_due[$];
  int q_line[$];
  bit q_inv[$];
  bit q_hit[$];
  bit q_mod[$];
  bit e_hit_n = 1, e_hitm_n = 1, e_upd = 0, e_ust = 0, e_wbr = 0, e_err = 0;
  int e_uline = 0, e_wline = 0;
  int mcyc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_due.delete(); q_line.delete(); q_inv.delete(); q_hit.delete(); q_mod.delete();
      e_hit_n = 1; e_hitm_n = 1; e_upd = 0; e_wbr = 0; e_err = 0;
      mcyc = 0;
    end else begin
      bit old_hitm_n;
      bit blocked;
      int ln;
      mcyc++;
      old_hitm_n = e_hitm_n;
      blocked = !old_hitm_n;
      foreach (q_mod[i]) if (q_mod[i]) blocked = 1;
      e_upd = 0; e_wbr = 0;
      if (!old_hitm_n && wb_done) e_hitm_n = 1;
      if (q_due.size() > 0 && q_due[0] == mcyc) begin
        e_hit_n = !q_hit[0];
        if (q_hit[0]) begin e_upd = 1; e_uline = q_line[0]; e_ust = q_inv[0]; end
        if (q_mod[0]) begin e_hitm_n = 0; e_wbr = 1; e_wline = q_line[0]; end
        void'(q_due.pop_front()); void'(q_line.pop_front()); void'(q_inv.pop_front());
        void'(q_hit.pop_front()); void'(q_mod.pop_front());
      end
      e_err = 0;
      if (!snp_strobe_n) begin
        if (blocked) e_err = 1;
        else begin
          ln = int'(snp_addr >> OFS_W);
          q_due.push_back(mcyc + 2); q_line.push_back(ln); q_inv.push_back(snp_inval);
          q_hit.push_back(t_iv[ln] | t_dv[ln]); q_mod.push_back(t_dv[ln] & t_dm[ln]);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R1 R2 R3 hit_n", hit_n, e_hit_n);
      chk("R4 R5 hitm_n", hitm_n, e_hitm_n);
      chk("R6 R7 upd_vld", upd_vld, e_upd);
      if (e_upd) begin
        chk("R6 R8 upd_line", upd_line, e_uline);
        chk("R6 upd_state", upd_state, e_ust);
      end
      chk("R9 wb_req", wb_req, e_wbr);
      if (e_wbr) chk("R9 wb_line", wb_line, e_wline);
      chk("R10 snp_err", snp_err, e_err);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  // One-clock strobe; afterwards address and invalidate are scrambled (R8).
  task automatic inquire(input int line, input bit inv);
    snp_strobe_n = 0; snp_inval = inv;
    snp_addr = ADDR_W'((line << OFS_W) | (cyc & ((1 << OFS_W) - 1)));
    tick();
    snp_strobe_n = 1; snp_inval = !inv; snp_addr = ~snp_addr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  int lfsr = 32'h1ace;

  initial begin
    for (int i = 0; i < NLINES; i++) begin t_iv[i] = 0; t_dv[i] = 0; t_dm[i] = 0; end
    t_iv[1] = 1; t_dv[2] = 1; t_dv[3] = 1; t_dm[3] = 1;
    t_iv[4] = 1; t_dv[4] = 1; t_dm[4] = 1; t_iv[5] = 1; t_dm[5] = 1;
    idle(3);
    // R11: reset state
    chk("R11 hit_n", hit_n, 1); chk("R11 hitm_n", hitm_n, 1);
    chk("R11 upd_vld", upd_vld, 0); chk("R11 wb_req", wb_req, 0); chk("R11 snp_err", snp_err, 0);
    rst_n = 1; cmp_on = 1;
    idle(2);
    inquire(1, 0); idle(1);
    chk("R1 latency: not yet", hit_n, 1);
    tick(); chk("R1 hit after two clocks", hit_n, 0); chk("R6 shared", upd_state, 0);
    idle(5); chk("R3 hit held", hit_n, 0);
    inquire(9, 1); idle(4); chk("R2 miss", hit_n, 1);
    inquire(2, 1); idle(4);
    inquire(5, 0); idle(4); chk("R4 dmod without dvalid", hitm_n, 1);
    // R12 back-to-back
    inquire(1, 1); inquire(9, 0); inquire(2, 0); idle(4);
    // modified hit, refusals while pending, release
    inquire(3, 1); inquire(1, 0); inquire(2, 0); idle(3); inquire(1, 0);
    chk("R5 hitm held", hitm_n, 0);
    wb_done = 1; snp_strobe_n = 0; snp_addr = 12'h010; tick();
    wb_done = 0; snp_strobe_n = 1; idle(2);
    chk("R5 released", hitm_n, 1);
    wb_done = 1; idle(2); wb_done = 0;
    inquire(1, 0); inquire(4, 0); idle(4);
    wb_done = 1; tick(); wb_done = 0; idle(2);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      wb_done = (lfsr[7:5] == 0);
      if (lfsr[1:0] != 0) inquire(lfsr[10:8], lfsr[11]);
      else tick();
    end
    wb_done = 1; idle(3); wb_done = 0; idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule